// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switch

This block takes two clocks with no phase or frequency relation and drives one output clock from whichever source the select input asks for. A plain multiplexer would cut a pulse short whenever the select moved. Here a handover goes through an idle phase, with `clk_out` held low, so the output never carries a glitch or a runt pulse. The outgoing source is switched off by logic running on its own clock. Only after a synchronized copy of "source off" reaches the incoming domain does logic running on the incoming clock switch that source on.

The control state machine lives in the clk_a domain and runs on the falling edge of clk_a. It has four states:
- `SW_ACTIVE_A`: clk_a drives the output.
- `SW_IDLE_TO_B`: clk_a is off and a grant is on its way to the clk_b domain.
- `SW_ACTIVE_B`: the clk_b domain has confirmed that it is on.
- `SW_IDLE_TO_A`: the grant is withdrawn and the machine waits to see clk_b off.

Its transitions are:
- `SW_ACTIVE_A` to `SW_IDLE_TO_B` when the select asks for B.
- `SW_IDLE_TO_B` to `SW_ACTIVE_B` when the synchronized B enable reads 1.
- `SW_ACTIVE_B` to `SW_IDLE_TO_A` when the select asks for A.
- `SW_IDLE_TO_A` to `SW_ACTIVE_A`, or to `SW_IDLE_TO_B`, once the synchronized B enable reads 0.

A two-state follower in the clk_b domain (`LEG_OFF`, `LEG_ON`) tracks the synchronized grant. It goes `LEG_OFF` to `LEG_ON` on grant and `LEG_ON` to `LEG_OFF` on its withdrawal, on the falling edge of clk_b.

Each domain has its own reset synchronizer. The output therefore stays low after reset until the selected source has been enabled.

Top module: `clock_handover_switch`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0. After reset is released, the output stays low until the source chosen by `use_b` is enabled, and then it follows that source.
- R2: `use_b` = 0 selects clk_a and `use_b` = 1 selects clk_b. Once the select has been stable long enough for a handover to finish, `clk_out` equals the selected clock.
- R3: The two source enables are never both 1. After settling, `clk_out` equals exactly one source and is never the OR of both.
- R4: For a switch from A to B, clk_a is disabled first, by clk_a-domain logic. The B side is enabled only after that idle condition has crossed through a synchronizer of at least two flip-flops. This holds even while clk_b is stopped.
- R5: A switch from B back to A is the mirror sequence. clk_b is disabled in its own domain, and clk_a is enabled only after a synchronized copy of that disable has been seen.
- R6: Each enable changes only while its own clock is low. Every high and every low phase of `clk_out` lasts at least the shorter source half-period.
- R7: While neither source is enabled (the idle states), `clk_out` is held at 0.
- R8: A select change that arrives during a handover is acted on only after that handover completes. The output ends up following the last select value, whatever the timing of the toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First source clock |
| clk_b | input | 1 | Second source clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| use_b | input | 1 | Asynchronous select: 0 picks clk_a, 1 picks clk_b |
| clk_out | output | 1 | Switched output clock |

## Verification
The properties assume that neither source produces pulses shorter than its nominal half-period. They also assume that reset is applied while the enables are already off, or that a truncated pulse at reset assertion is acceptable. Both clocks must keep running whenever a handover needs their domain.

The bench uses fixed half-periods of 2.5 ns and 3.7 ns. It places every select change on a 0.1 ns grid offset by 0.05 ns, so the select never coincides with a clock edge. It sweeps the select timing across the beat of the two clocks. It stops clk_b only while the design is parked on A or idle, never while B drives the output.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

    // Control states of the clk_a-domain owner machine
    typedef enum logic [1:0] {
        SW_IDLE_TO_A = 2'd0,
        SW_ACTIVE_A  = 2'd1,
        SW_IDLE_TO_B = 2'd2,
        SW_ACTIVE_B  = 2'd3
    } sw_state_e;

    // States of the clk_b-domain follower
    typedef enum logic {
        LEG_OFF = 1'b0,
        LEG_ON  = 1'b1
    } leg_state_e;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    import clksw_pkg::*;

    localparam int DEPTH = (STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : STAGES;

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {DEPTH{RESET_VAL}};
        else        chain <= {chain[DEPTH-2:0], d};
    end

    assign q = chain[DEPTH-1];
endmodule

// File: rtl/clksw_ctrl_a.sv
`timescale 1ns/1ps
module clksw_ctrl_a (
    input  logic clk,
    input  logic rst_n,
    input  logic want_b,
    input  logic b_on_s,
    output logic en,
    output logic grant
);
    import clksw_pkg::*;

    sw_state_e state_q, state_d;

    // State register, falling edge of clk_a
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_IDLE_TO_A;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE_TO_A: if (!b_on_s) state_d = want_b ? SW_IDLE_TO_B : SW_ACTIVE_A;
            SW_ACTIVE_A:  if (want_b)  state_d = SW_IDLE_TO_B;
            SW_IDLE_TO_B: if (b_on_s)  state_d = SW_ACTIVE_B;
            SW_ACTIVE_B:  if (!want_b) state_d = SW_IDLE_TO_A;
            default:                   state_d = SW_IDLE_TO_A;
        endcase
    end

    // Registered outputs: the enable is a flop, so the gate input is clean
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en    <= 1'b0;
            grant <= 1'b0;
        end else begin
            en    <= (state_d == SW_ACTIVE_A);
            grant <= (state_d == SW_IDLE_TO_B) || (state_d == SW_ACTIVE_B);
        end
    end
endmodule

// File: rtl/clksw_leg_b.sv
`timescale 1ns/1ps
module clksw_leg_b (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_s,
    output logic en
);
    import clksw_pkg::*;

    leg_state_e state_q, state_d;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LEG_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_OFF: if (grant_s)  state_d = LEG_ON;
            LEG_ON:  if (!grant_s) state_d = LEG_OFF;
            default:               state_d = LEG_OFF;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en <= 1'b0;
        else        en <= (state_d == LEG_ON);
    end
endmodule

// File: rtl/clock_handover_switch.sv
`timescale 1ns/1ps
module clock_handover_switch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic use_b,
    output logic clk_out
);
    logic rst_a_n, rst_b_n;
    logic want_b_a;
    logic b_on_sync;
    logic grant_ab, grant_sync;
    logic en_a, en_b;

    // Per-domain reset release
    clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_a (
        .clk(clk_a), .rst_n(rst_n), .d(1'b1), .q(rst_a_n)
    );
    clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_b (
        .clk(clk_b), .rst_n(rst_n), .d(1'b1), .q(rst_b_n)
    );

    // Crossings into the clk_a domain
    clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sel_a (
        .clk(clk_a), .rst_n(rst_a_n), .d(use_b), .q(want_b_a)
    );
    clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_bon_a (
        .clk(clk_a), .rst_n(rst_a_n), .d(en_b), .q(b_on_sync)
    );

    // Crossing into the clk_b domain
    clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_grant_b (
        .clk(clk_b), .rst_n(rst_b_n), .d(grant_ab), .q(grant_sync)
    );

    clksw_ctrl_a u_ctrl_a (
        .clk(clk_a), .rst_n(rst_a_n), .want_b(want_b_a),
        .b_on_s(b_on_sync), .en(en_a), .grant(grant_ab)
    );

    clksw_leg_b u_leg_b (
        .clk(clk_b), .rst_n(rst_b_n), .grant_s(grant_sync), .en(en_b)
    );

    // Gate each source with its falling-edge enable, then merge
    assign clk_out = (clk_a & en_a) | (clk_b & en_b);
endmodule

// File: rtl/clksw_checker.sv
`timescale 1ns/1ps
module clksw_checker (
    input logic clk_a,
    input logic clk_b,
    input logic rst_n,
    input logic en_a,
    input logic en_b,
    input logic grant,
    input logic b_on_s,
    input logic clk_out
);
    // R3: never two sources at once
    always @(en_a or en_b) begin
        assert_exclusive_R3: assert (!(en_a && en_b))
            else $error("both sources enabled");
    end

    // R6: enable A moves only while clk_a is low
    always @(en_a) begin
        if (rst_n) begin
            assert_en_a_low_phase_R6: assert (!clk_a)
                else $error("en_a changed while clk_a high");
        end
    end

    // R6: enable B moves only while clk_b is low
    always @(en_b) begin
        if (rst_n) begin
            assert_en_b_low_phase_R6: assert (!clk_b)
                else $error("en_b changed while clk_b high");
        end
    end

    // R4: grant to B appears only with A already off
    assert_grant_after_a_off_R4: assert property (
        @(negedge clk_a) disable iff (!rst_n) $rose(grant) |-> !en_a
    ) else $error("grant raised with en_a on");

    // R5: A is enabled only after synchronized B-off was seen
    assert_a_on_after_b_off_R5: assert property (
        @(negedge clk_a) disable iff (!rst_n) $rose(en_a) |-> !$past(b_on_s)
    ) else $error("en_a raised while B seen on");

    // R7: idle holds the output low
    assert_idle_low_R7: assert property (
        @(posedge clk_a) disable iff (!rst_n) (!en_a && !en_b) |-> !clk_out
    ) else $error("clk_out high while idle");
endmodule

bind clock_handover_switch clksw_checker u_clksw_checker (
    .clk_a  (clk_a),
    .clk_b  (clk_b),
    .rst_n  (rst_n),
    .en_a   (en_a),
    .en_b   (en_b),
    .grant  (grant_ab),
    .b_on_s (b_on_sync),
    .clk_out(clk_out)
);

// File: tb/tb_clock_handover_switch.sv
`timescale 1ns/1ps
module tb_clock_handover_switch;
    localparam real A_HALF   = 2.5;   // 200 MHz
    localparam real B_HALF   = 3.7;
    localparam real MIN_HALF = (A_HALF < B_HALF) ? A_HALF : B_HALF;
    localparam real SETTLE   = 200.0;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic b_run = 1'b1;
    logic rst_n = 1'b0;
    logic use_b = 1'b0;
    logic clk_out;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  seen_edge = 1'b0;
    real t_last = 0.0;

    clock_handover_switch #(.SYNC_STAGES(2)) dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .use_b(use_b), .clk_out(clk_out)
    );

    initial forever begin #(A_HALF); clk_a = ~clk_a; end
    initial forever begin #(B_HALF); if (b_run) clk_b = ~clk_b; end

    // R6: every phase of the output is at least the shorter half-period
    always @(clk_out) begin
        if (rst_n && seen_edge) begin
            checks++;
            if ($realtime - t_last < MIN_HALF - 0.001) begin
                errors++;
                $display("FAIL R6: phase %0.3f ns, expected >= %0.3f ns at %0t",
                         $realtime - t_last, MIN_HALF, $time);
            end
        end
        if (rst_n) seen_edge = 1'b1;
        t_last = $realtime;
    end

    // Sample the output over several points and compare with the chosen source
    task automatic check_follow(input bit want_b, input string req);
        for (int i = 0; i < 8; i++) begin
            logic exp_v;
            #0.9;
            exp_v = want_b ? clk_b : clk_a;
            checks++;
            if (clk_out !== exp_v) begin
                errors++;
                $display("FAIL %s: clk_out=%b expected %b (source %s) at %0t",
                         req, clk_out, exp_v, want_b ? "B" : "A", $time);
            end
        end
    endtask

    task automatic check_low(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            #0.9;
            checks++;
            if (clk_out !== 1'b0) begin
                errors++;
                $display("FAIL %s: clk_out=%b expected 0 at %0t", req, clk_out, $time);
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected end before %0t", $time);
        finish_run();
    end

    initial begin
        #0.05;
        // R1: output held low in reset
        check_low(6, "R1");
        rst_n = 1'b1;
        check_low(1, "R1");
        #(SETTLE);
        check_follow(1'b0, "R1");

        // R2/R4/R5: sweep the select timing across the beat of the clocks
        for (int off = 0; off < 20; off++) begin
            #(0.3 * off);
            use_b = 1'b1;
            #(SETTLE);
            check_follow(1'b1, "R4");
            #(0.3 * off);
            use_b = 1'b0;
            #(SETTLE);
            check_follow(1'b0, "R5");
        end
        check_follow(1'b0, "R2");

        // R8: a toggle back during a handover ends on the final select
        for (int k = 0; k < 6; k++) begin
            real hold;
            hold = 0.4 + 5.9 * k;
            use_b = 1'b1;
            #(hold);
            use_b = 1'b0;
            #(SETTLE);
            check_follow(1'b0, "R8");
        end
        use_b = 1'b1;
        #(SETTLE);
        check_follow(1'b1, "R2");
        for (int k = 0; k < 6; k++) begin
            real hold;
            hold = 0.7 + 4.3 * k;
            use_b = 1'b0;
            #(hold);
            use_b = 1'b1;
            #(SETTLE);
            check_follow(1'b1, "R8");
        end
        use_b = 1'b0;
        #(SETTLE);
        check_follow(1'b0, "R3");

        // R7/R4: stop clk_b, ask for B: A goes off, output idles low
        b_run = 1'b0;
        #20;
        use_b = 1'b1;
        #100;
        check_low(20, "R7");
        b_run = 1'b1;
        #(SETTLE);
        check_follow(1'b1, "R4");
        use_b = 1'b0;
        #(SETTLE);
        check_follow(1'b0, "R5");

        finish_run();
    end
endmodule